// File: doc/BRIEF.md
# Cascaded FIFO Churn Heater

This block keeps a long ring of small synchronous FIFOs permanently busy so that every memory in the ring rewrites its contents cycle after cycle. It has no traffic of its own to carry. A linear feedback shift register fills the head FIFO with pseudo-random words. After that, each FIFO's read word becomes the next FIFO's write word, and the word read from the tail FIFO is written back into the head. The amount of data in the ring therefore never changes, and the words keep circulating for as long as the block is enabled.

A two-state controller sequences the block. In `ST_FILL` the head FIFO takes one generator word per enabled cycle, and no stage-to-stage transfer takes place. The transition `FILL_DONE` fires on the enabled cycle that writes the last free head slot, and it leads to `ST_CHURN`. In `ST_CHURN` every hop of the ring moves at most one word per enabled cycle. The only way back to `ST_FILL` is through reset. A low enable freezes the whole block in whichever state it is in.

Top module: `churn_heater`

## Requirements
- R1: While reset is high, and in the cycle after it ends, every FIFO reports empty, none reports full and `tail_pop` is low.
- R2: In fill, the head FIFO receives DEPTH generator words, one per enabled cycle. The first word is SEED. Each later word is the previous word shifted right by one, XORed with MASK (default 32'h80200003) when the bit shifted out was 1. After DEPTH enabled edges the head (bit 0 of the flag buses) is full and not empty.
- R3: No word leaves the head FIFO during fill, so all stages other than the head stay empty until the fill is complete.
- R4: A hop moves one word from stage i to stage i+1 in a cycle only if stage i is not empty and stage i+1 is not full. One enabled edge after the fill, the head is no longer full, stage 1 holds a word and stage 2 is still empty.
- R5: The word read from the tail stage is written into the head, so the ring keeps exactly DEPTH words and words keep leaving the tail for as long as the block is enabled.
- R6: The words leaving the tail follow the prefill order: word k mod DEPTH of the prefill sequence, with no word lost or repeated, across any pattern of enable.
- R7: With enable held high from reset, `tail_pop` first goes high in the cycle that follows the (DEPTH+STAGES-1)-th enabled edge.
- R8: While enable is low, `tail_pop` is low and no FIFO is read or written. Every empty and full flag keeps its value across such an edge, in both states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows the block to advance when high |
| tail_word | output | WIDTH | Word at the read side of the tail FIFO |
| tail_pop | output | 1 | High when `tail_word` leaves the tail FIFO at the coming edge |
| stage_empty | output | STAGES | Per-FIFO empty flags, bit i for stage i |
| stage_full | output | STAGES | Per-FIFO full flags, bit i for stage i |

## Verification
The flags are registered, so their values after the edge that writes or reads a FIFO are sampled half a cycle after that edge. `tail_pop` and `tail_word` are combinational from the current flags and enable, so they are sampled at the same point and describe the pop taking effect at the next edge. The first tail word is expected DEPTH+STAGES-1 enabled edges after reset: DEPTH edges of fill, then one hop per edge. Because enable changes one nanosecond after an edge and every sample is taken at the falling edge, each check knows exactly which enable value applied to the edge it inspects.

// File: rtl/churn_pkg.sv
package churn_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_CHURN = 1'b1
    } churn_state_t;

    localparam logic [31:0] DEF_SEED = 32'hC0DE_5EED;
    localparam logic [31:0] DEF_MASK = 32'h8020_0003;

endpackage

// File: rtl/churn_lfsr.sv
module churn_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [WIDTH-1:0] SEED  = WIDTH'(32'hC0DE_5EED),
    parameter logic [WIDTH-1:0] MASK  = WIDTH'(32'h8020_0003)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] next_word;

    always_comb begin
        next_word = {1'b0, word[WIDTH-1:1]};
        if (word[0]) begin
            next_word = next_word ^ MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= SEED;
        end else if (step) begin
            word <= next_word;
        end
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        step |=> (word != '0)) else $error("generator reached zero"); // R2

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(word)) else $error("generator moved without step"); // R2

endmodule

// File: rtl/churn_fifo.sv
module churn_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAPACITY  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (fill == '0);
    assign full    = (fill == CAPACITY);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full) else $error("write into full stage"); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty) else $error("read from empty stage"); // R4

endmodule

// File: rtl/churn_ctrl.sv
module churn_ctrl
    import churn_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic fill_wr,
    output logic lfsr_step,
    output logic churn_go
);

    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] LAST_FILL = FW'(DEPTH - 1);

    churn_state_t state;
    churn_state_t state_nxt;
    logic [FW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
        end else if (fill_wr) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (enable && (fill_cnt == LAST_FILL)) begin
                    state_nxt = ST_CHURN;
                end
            end
            ST_CHURN: begin
                state_nxt = ST_CHURN;
            end
            default: state_nxt = ST_FILL;
        endcase
    end

    always_comb begin
        fill_wr   = 1'b0;
        lfsr_step = 1'b0;
        churn_go  = 1'b0;
        unique case (state)
            ST_FILL: begin
                fill_wr   = enable;
                lfsr_step = enable;
            end
            ST_CHURN: begin
                churn_go  = enable;
            end
            default: begin
                fill_wr   = 1'b0;
            end
        endcase
    end

    AST_CHURN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHURN) |=> (state == ST_CHURN)) else $error("left churn"); // R3

    AST_FILL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL) |-> (fill_cnt < FW'(DEPTH))) else $error("fill overran"); // R2

endmodule

// File: rtl/churn_heater.sv
module churn_heater
    import churn_pkg::*;
#(
    parameter int          WIDTH  = 32,
    parameter int          STAGES = 130,
    parameter int          DEPTH  = 8,
    parameter logic [WIDTH-1:0] SEED = WIDTH'(DEF_SEED),
    parameter logic [WIDTH-1:0] MASK = WIDTH'(DEF_MASK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    output logic [WIDTH-1:0]  tail_word,
    output logic              tail_pop,
    output logic [STAGES-1:0] stage_empty,
    output logic [STAGES-1:0] stage_full
);

    logic             fill_wr;
    logic             lfsr_step;
    logic             churn_go;
    logic [WIDTH-1:0] gen_word;
    logic [STAGES-1:0] hop;
    logic [WIDTH-1:0] rdata [STAGES];

    churn_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .fill_wr   (fill_wr),
        .lfsr_step (lfsr_step),
        .churn_go  (churn_go)
    );

    churn_lfsr #(
        .WIDTH (WIDTH),
        .SEED  (SEED),
        .MASK  (MASK)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .step (lfsr_step),
        .word (gen_word)
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int UP = (g == 0) ? STAGES - 1 : g - 1;
        localparam int DN = (g == STAGES - 1) ? 0 : g + 1;

        logic             wr_en;
        logic [WIDTH-1:0] wr_data;

        assign hop[g] = churn_go & ~stage_empty[g] & ~stage_full[DN];

        if (g == 0) begin : g_head
            assign wr_en   = fill_wr | hop[UP];
            assign wr_data = fill_wr ? gen_word : rdata[UP];
        end else begin : g_body
            assign wr_en   = hop[UP];
            assign wr_data = rdata[UP];
        end

        churn_fifo #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .rd_en   (hop[g]),
            .rd_data (rdata[g]),
            .empty   (stage_empty[g]),
            .full    (stage_full[g])
        );
    end

    assign tail_word = rdata[STAGES-1];
    assign tail_pop  = hop[STAGES-1];

    AST_FILL_NO_HOP: assert property (@(posedge clk) disable iff (rst)
        fill_wr |-> (hop == '0)) else $error("hop during fill"); // R3

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(stage_empty) && $stable(stage_full))) else $error("flags moved while off"); // R8

    AST_NO_POP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !tail_pop) else $error("pop while off"); // R8

    AST_RING_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        churn_go |-> !(&stage_empty)) else $error("ring lost its words"); // R5

    AST_TAIL_REFILLS_HEAD: assert property (@(posedge clk) disable iff (rst)
        (tail_pop && !hop[0]) |=> !stage_empty[0]) else $error("tail word not in head"); // R5

endmodule

// File: tb/churn_heater_bench.sv
`timescale 1ns/1ps
module churn_heater_bench;

    localparam int W = 32;
    localparam int N = 6;
    localparam int D = 4;
    localparam logic [31:0] SEED = 32'hC0DE_5EED;
    localparam logic [31:0] MASK = 32'h8020_0003;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable = 1'b0;
    logic [W-1:0] tail_word;
    logic         tail_pop;
    logic [N-1:0] stage_empty;
    logic [N-1:0] stage_full;

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    int pops = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    churn_heater #(
        .WIDTH  (W),
        .STAGES (N),
        .DEPTH  (D),
        .SEED   (SEED),
        .MASK   (MASK)
    ) u_churn_heater (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .tail_word   (tail_word),
        .tail_pop    (tail_pop),
        .stage_empty (stage_empty),
        .stage_full  (stage_full)
    );

    function automatic logic [31:0] gen_next(logic [31:0] s);
        logic [31:0] r;
        r = {1'b0, s[31:1]};
        if (s[0]) r = r ^ MASK;
        return r;
    endfunction

    function automatic logic [31:0] prefill_word(int k);
        logic [31:0] s;
        s = SEED;
        for (int i = 0; i < k; i++) s = gen_next(s);
        return s;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // tail monitor: order of words and silence while off
    always @(negedge clk) begin
        if (rst) begin
            exp_idx = 0;
        end else begin
            if (!enable) begin
                check(!tail_pop, "R8", "tail_pop while enable low", 64'(tail_pop), 64'd0);
            end
            if (tail_pop) begin
                check(tail_word == prefill_word(exp_idx % D), "R6", "tail word order",
                      64'(tail_word), 64'(prefill_word(exp_idx % D)));
                exp_idx++;
                pops++;
            end
        end
    end

    task automatic tick(bit en_next);
        @(posedge clk);
        #1 enable = en_next;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 rst = 1'b1;
        enable = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(stage_empty == '1, "R1", "empty flags in reset", 64'(stage_empty), 64'(N'('1)));
        check(stage_full == '0, "R1", "full flags in reset", 64'(stage_full), 64'd0);
        check(!tail_pop, "R1", "tail_pop in reset", 64'(tail_pop), 64'd0);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // enable held high from now: fill, first hop, first tail word
    task automatic fill_and_first_pop();
        int e;
        int first;
        first = -1;
        #0 enable = 1'b1;
        for (e = 1; e <= 4 * (D + N); e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 1) begin
                check(stage_empty[0] == 1'b0, "R2", "head written on first edge", 64'(stage_empty[0]), 64'd0);
            end
            if (e < D) begin
                check(stage_empty[N-1:1] == '1, "R3", "downstream empty in fill",
                      64'(stage_empty[N-1:1]), 64'(N'('1) >> 1));
            end
            if (e == D) begin
                check(stage_full[0] && !stage_empty[0], "R2", "head full after fill",
                      64'({stage_full[0], stage_empty[0]}), 64'b10);
                check(stage_empty[N-1:1] == '1, "R3", "downstream empty at fill end",
                      64'(stage_empty[N-1:1]), 64'(N'('1) >> 1));
            end
            if (e == D + 1) begin
                check(!stage_full[0] && !stage_empty[1] && stage_empty[2], "R4", "one hop after fill",
                      64'({stage_full[0], stage_empty[1], stage_empty[2]}), 64'b001);
            end
            if (tail_pop && first < 0) first = e;
            if (first >= 0) break;
        end
        check(first == D + N - 1, "R7", "edge of first tail word", 64'(first), 64'(D + N - 1));
    endtask

    initial begin
        logic [N-1:0] pe;
        logic [N-1:0] pf;
        bit en_prev;
        int pops_before;
        void'($urandom(32'd1234));

        do_reset();
        fill_and_first_pop();

        // random enable pattern while churning
        for (int c = 0; c < 3000; c++) begin
            en_prev = enable;
            pe = stage_empty;
            pf = stage_full;
            tick(($urandom % 4) != 0);
            if (!en_prev) begin
                check(stage_empty == pe && stage_full == pf, "R8", "flags held while off",
                      64'({stage_empty, stage_full}), 64'({pe, pf}));
            end
        end

        // enable held high: ring keeps delivering
        pops_before = pops;
        for (int c = 0; c < 10 * N; c++) tick(1'b1);
        check(pops - pops_before >= 10 * D - D, "R5", "tail keeps delivering",
              64'(pops - pops_before), 64'(10 * D - D));

        // long pause, then resume without loss
        for (int c = 0; c < 20; c++) tick(1'b0);
        pops_before = pops;
        for (int c = 0; c < 4 * N; c++) tick(1'b1);
        check(pops - pops_before >= 2 * D, "R5", "deliveries after pause",
              64'(pops - pops_before), 64'(2 * D));

        // reset, hold enable low during fill state
        do_reset();
        for (int c = 0; c < 5; c++) begin
            tick(1'b0);
            check(stage_empty == '1, "R8", "no fill while off", 64'(stage_empty), 64'(N'('1)));
        end
        fill_and_first_pop();

        // fill interrupted by enable gaps
        do_reset();
        for (int c = 0; c < 2 * D + 6; c++) begin
            en_prev = enable;
            pe = stage_empty;
            pf = stage_full;
            tick(c % 2 == 0);
            if (!en_prev) begin
                check(stage_empty == pe && stage_full == pf, "R8", "fill held while off",
                      64'({stage_empty, stage_full}), 64'({pe, pf}));
            end
        end
        for (int c = 0; c < 8 * N; c++) tick(1'b1);
        check(pops > 0 && exp_idx >= D, "R6", "words after gapped fill", 64'(exp_idx), 64'(D));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule